// File: doc/BRIEF.md
# Serial Controller DMA FIFO Bridge

This block sits between a host register window and a two-channel serial controller core. It holds one byte-wide transmit FIFO and one byte-wide receive FIFO, each 1024 entries deep. The controller signals through per-channel request lines when it wants a byte. The block answers each request with a one-cycle strobe: a transmit strobe carries the head byte of the transmit FIFO, and a receive acknowledge captures the byte the controller presents.

A receive-source bit in the configuration register chooses which controller channel feeds the receive FIFO. The same bit moves transmit service from the channel A data-terminal request line to the channel A wait/request line. That swap frees channel B's wait/request line for receive.

The host reaches the block through a 16-byte register window with single-cycle reads and writes. It fills the transmit FIFO and drains the receive FIFO through a data port. It can reset each FIFO on its own and read a status byte of empty, full and half-full flags. Sticky interrupt causes, including an idle timeout on the receive FIFO, are cleared when the host reads them. A selectable interrupt output routes one of three sources.

Top module: `scfb_bridge`

## Requirements
- R1: After reset, both FIFOs are empty and every writable register is zero, so controller transfers are disabled. The status register at 0x9 therefore reads 0x11, and the interrupt status register at 0x8 reads 0x00.
- R2: A host write to the data port 0xE pushes `host_wdata` into the transmit FIFO unless that FIFO is full or held in reset. A host read of 0xE returns the receive FIFO head and pops it. When the receive FIFO is empty, the read returns 0x00 and pops nothing.
- R3: In every cycle where three conditions hold, `tx_stb` is 1, `tx_data` equals the transmit FIFO head, and that byte is removed. The conditions are: enable (configuration 0x7 bit 0) is 1, the transmit request is high, and the transmit FIFO is not empty. The transmit request is `ch_a_dreq` when receive-source (0x7 bit 1) is 0, and `ch_a_wreq` when it is 1.
- R4: With receive-source 0, `ch_a_wreq` requests receive: the byte on `rxd_a` is captured and `rx_ack_a` pulses. With receive-source 1, `ch_b_wreq` requests receive from `rxd_b` with `rx_ack_b`. In either case the other channel's receive request is ignored. Receive acceptance also requires the enable bit.
- R5: Each FIFO holds exactly 1024 bytes. Host writes to a full transmit FIFO are dropped. A full receive FIFO acknowledges no request.
- R6: The status register 0x9 reports transmit empty, full and half-full in bits 0, 1 and 2. It reports receive empty, full and half-full in bits 4, 5 and 6. Half-full means 512 or more bytes held. Writes to 0x9 have no effect.
- R7: Control register 0xA bit 0 resets the transmit FIFO and bit 1 resets the receive FIFO. While a bit is set, its FIFO is emptied from the next clock, accepts nothing and issues nothing. Clearing the bit resumes normal operation with an empty FIFO.
- R8: Interrupt status 0x8 latches three causes. Bit 0 is set when a transmit strobe drains the transmit FIFO to empty. Bit 1 is set when a receive capture brings the receive FIFO to 512 bytes. Bit 2 is the receive timeout. Each bit stays set until the host reads 0x8, which clears all bits except causes arriving in that same cycle.
- R9: Register 0xD holds a timeout limit. A tick occurs every 4 clocks. The block counts ticks while the receive FIFO is non-empty and unreset and no byte arrives. When the count reaches a nonzero limit, bit 2 is set once. A new byte, an empty FIFO or a receive reset restarts the count. A limit of 0 disables the timeout.
- R10: Configuration bits 5:4 select the `irq` output: 0 gives 0, 1 passes `ctrl_irq`, 2 gives the OR of the interrupt status bits, and 3 passes `test_irq`.
- R11: While enable is 0, no transmit strobe or receive acknowledge occurs whatever the request lines do. Host access to both FIFOs still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register offset in the window |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe, one cycle per read (side effects) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| ch_a_wreq | input | 1 | Channel A wait/request line |
| ch_a_dreq | input | 1 | Channel A data-terminal request line |
| ch_b_wreq | input | 1 | Channel B wait/request line |
| rxd_a | input | 8 | Receive byte offered by channel A |
| rxd_b | input | 8 | Receive byte offered by channel B |
| tx_stb | output | 1 | Transmit byte strobe to channel A |
| tx_data | output | 8 | Transmit byte, valid with `tx_stb` |
| rx_ack_a | output | 1 | Channel A receive byte captured |
| rx_ack_b | output | 1 | Channel B receive byte captured |
| ctrl_irq | input | 1 | Interrupt from the serial controller |
| test_irq | input | 1 | Interrupt from the line test logic |
| irq | output | 1 | Selected interrupt output |

## Verification
The transfer logic is driven with several request patterns:
- Bursts of transmit requests on a partly filled FIFO separate a correct drain from one that strobes too often or misses the final byte.
- Requests with both receive-source settings, with the unselected line held high, show whether the pin swap routes transmit and receive correctly.
- Long unbroken receive and transmit streams across 1024 entries expose off-by-one errors in the full and half-full flags and in the half-full interrupt cause.
- A single captured byte followed by silence distinguishes a timeout that fires once at the programmed tick from one that repeats or never fires.
- A reset bit held during requests shows whether the FIFO really stays empty.

// File: rtl/scfb_pkg.sv
package scfb_pkg;

  localparam logic [3:0] OFS_CFG  = 4'h7;
  localparam logic [3:0] OFS_ISR  = 4'h8;
  localparam logic [3:0] OFS_FSR  = 4'h9;
  localparam logic [3:0] OFS_FCR  = 4'hA;
  localparam logic [3:0] OFS_TMO  = 4'hD;
  localparam logic [3:0] OFS_DATA = 4'hE;

  typedef enum logic [1:0] {
    IRQ_NONE = 2'd0,
    IRQ_CTRL = 2'd1,
    IRQ_FIFO = 2'd2,
    IRQ_TEST = 2'd3
  } irq_sel_e;

  typedef struct packed {
    logic half;
    logic full;
    logic empty;
  } fifo_flags_t;

  // Occupancy flags from a fill count.
  function automatic fifo_flags_t flags_of(input int unsigned cnt, input int unsigned depth);
    fifo_flags_t f;
    f.empty = (cnt == 0);
    f.full  = (cnt == depth);
    f.half  = (cnt >= depth / 2);
    return f;
  endfunction

  // Status byte layout: transmit in the low nibble, receive in the high nibble.
  function automatic logic [7:0] fsr_pack(input fifo_flags_t t, input fifo_flags_t r);
    return {1'b0, r.half, r.full, r.empty, 1'b0, t.half, t.full, t.empty};
  endfunction

  function automatic logic [7:0] cfg_pack(input logic en, input logic src, input irq_sel_e sel);
    return {2'b00, sel, 2'b00, src, en};
  endfunction

endpackage

// File: rtl/scfb_fifo.sv
module scfb_fifo #(
  parameter int DEPTH = 1024,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head = mem[rp];

endmodule

// File: rtl/scfb_rx_timeout.sv
module scfb_rx_timeout #(
  parameter int TICK_DIV = 4,
  parameter int TW       = 8,
  localparam int PW      = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          fire
);

  logic [PW-1:0] pre;
  logic          tick;
  logic [TW-1:0] idle;
  logic [TW-1:0] idle_nx;
  logic          fired;
  logic          counting;

  assign tick     = (pre == PW'(TICK_DIV - 1));
  assign idle_nx  = idle + 1'b1;
  assign counting = !restart && tick && !fired && (limit != '0);
  assign fire     = counting && (idle_nx == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle  <= '0;
      fired <= 1'b0;
    end else if (restart) begin
      idle  <= '0;
      fired <= 1'b0;
    end else if (counting) begin
      idle <= idle_nx;
      if (idle_nx == limit) fired <= 1'b1;
    end
  end

endmodule

// File: rtl/scfb_intr.sv
module scfb_intr
  import scfb_pkg::*;
#(
  parameter int NCAUSE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] ev,
  input  logic              rd_clr,
  input  irq_sel_e          sel,
  input  logic              ctrl_irq,
  input  logic              test_irq,
  output logic [NCAUSE-1:0] isr,
  output logic              irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= (rd_clr ? '0 : isr) | ev;
  end

  always_comb begin
    unique case (sel)
      IRQ_CTRL: irq = ctrl_irq;
      IRQ_FIFO: irq = |isr;
      IRQ_TEST: irq = test_irq;
      default:  irq = 1'b0;
    endcase
  end

endmodule

// File: rtl/scfb_bridge.sv
module scfb_bridge
  import scfb_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       ch_a_wreq,
  input  logic       ch_a_dreq,
  input  logic       ch_b_wreq,
  input  logic [7:0] rxd_a,
  input  logic [7:0] rxd_b,
  output logic       tx_stb,
  output logic [7:0] tx_data,
  output logic       rx_ack_a,
  output logic       rx_ack_b,
  input  logic       ctrl_irq,
  input  logic       test_irq,
  output logic       irq
);

  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int HALF = DEPTH / 2;

  // Configuration state
  logic       cfg_en;
  logic       cfg_rxsrc;
  irq_sel_e   cfg_isel;
  logic       fcr_tx;
  logic       fcr_rx;
  logic [7:0] tmo;

  // Decoded host accesses
  logic wr_cfg, wr_fcr, wr_tmo, wr_data, rd_data, isr_rd;

  // FIFO side
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0]    tx_head, rx_head, rx_byte;
  fifo_flags_t   tx_fl, rx_fl;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic          tx_req, rx_req;
  logic          tx_push, tx_pop, rx_push, rx_pop;

  // Interrupt causes
  logic       ev_tx_drain, ev_rx_half, ev_rx_tmo, any_ev;
  logic [2:0] isr;

  assign wr_cfg  = host_wr && (host_addr == OFS_CFG);
  assign wr_fcr  = host_wr && (host_addr == OFS_FCR);
  assign wr_tmo  = host_wr && (host_addr == OFS_TMO);
  assign wr_data = host_wr && (host_addr == OFS_DATA);
  assign rd_data = host_rd && (host_addr == OFS_DATA);
  assign isr_rd  = host_rd && (host_addr == OFS_ISR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en    <= 1'b0;
      cfg_rxsrc <= 1'b0;
      cfg_isel  <= IRQ_NONE;
      fcr_tx    <= 1'b0;
      fcr_rx    <= 1'b0;
      tmo       <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_en    <= host_wdata[0];
        cfg_rxsrc <= host_wdata[1];
        cfg_isel  <= irq_sel_e'(host_wdata[5:4]);
      end
      if (wr_fcr) begin
        fcr_tx <= host_wdata[0];
        fcr_rx <= host_wdata[1];
      end
      if (wr_tmo) tmo <= host_wdata;
    end
  end

  // Request pin steering: the receive-source bit swaps pin roles.
  assign tx_req  = cfg_rxsrc ? ch_a_wreq : ch_a_dreq;
  assign rx_req  = cfg_rxsrc ? ch_b_wreq : ch_a_wreq;
  assign rx_byte = cfg_rxsrc ? rxd_b : rxd_a;

  assign tx_fl    = flags_of(32'(tx_cnt), DEPTH);
  assign rx_fl    = flags_of(32'(rx_cnt), DEPTH);
  assign tx_empty = tx_fl.empty;
  assign tx_full  = tx_fl.full;
  assign rx_empty = rx_fl.empty;
  assign rx_full  = rx_fl.full;

  assign tx_push = wr_data && !tx_full && !fcr_tx;
  assign tx_pop  = cfg_en && tx_req && !tx_empty && !fcr_tx;
  assign rx_push = cfg_en && rx_req && !rx_full && !fcr_rx;
  assign rx_pop  = rd_data && !rx_empty && !fcr_rx;

  scfb_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fcr_tx),
    .push  (tx_push),
    .wdata (host_wdata),
    .pop   (tx_pop),
    .head  (tx_head),
    .count (tx_cnt)
  );

  scfb_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fcr_rx),
    .push  (rx_push),
    .wdata (rx_byte),
    .pop   (rx_pop),
    .head  (rx_head),
    .count (rx_cnt)
  );

  assign tx_stb   = tx_pop;
  assign tx_data  = tx_head;
  assign rx_ack_a = rx_push && !cfg_rxsrc;
  assign rx_ack_b = rx_push && cfg_rxsrc;

  assign ev_tx_drain = tx_pop && !tx_push && (tx_cnt == CW'(1));
  assign ev_rx_half  = rx_push && !rx_pop && (rx_cnt == CW'(HALF - 1));

  scfb_rx_timeout #(.TICK_DIV(TICK_DIV), .TW(8)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (rx_push || rx_empty || fcr_rx),
    .limit   (tmo),
    .fire    (ev_rx_tmo)
  );

  assign any_ev = ev_tx_drain || ev_rx_half || ev_rx_tmo;

  scfb_intr #(.NCAUSE(3)) u_intr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       ({ev_rx_tmo, ev_rx_half, ev_tx_drain}),
    .rd_clr   (isr_rd),
    .sel      (cfg_isel),
    .ctrl_irq (ctrl_irq),
    .test_irq (test_irq),
    .isr      (isr),
    .irq      (irq)
  );

  always_comb begin
    unique case (host_addr)
      OFS_CFG:  host_rdata = cfg_pack(cfg_en, cfg_rxsrc, cfg_isel);
      OFS_ISR:  host_rdata = {5'b0, isr};
      OFS_FSR:  host_rdata = fsr_pack(tx_fl, rx_fl);
      OFS_FCR:  host_rdata = {6'b0, fcr_rx, fcr_tx};
      OFS_TMO:  host_rdata = tmo;
      OFS_DATA: host_rdata = rx_empty ? 8'h00 : rx_head;
      default:  host_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/scfb_bridge_chk.sv
module scfb_bridge_chk #(
  parameter int DEPTH = 1024,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_stb,
  input logic          rx_ack_a,
  input logic          rx_ack_b,
  input logic          cfg_rxsrc,
  input logic          cfg_en,
  input logic          tx_empty,
  input logic          rx_full,
  input logic          fcr_tx,
  input logic          fcr_rx,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          isr_rd,
  input logic          any_ev,
  input logic [2:0]    isr
);

  assert_tx_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> !tx_empty);

  assert_ack_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rxsrc |-> !rx_ack_a) and (!cfg_rxsrc |-> !rx_ack_b));

  assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_ack_a, rx_ack_b}));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack_a || rx_ack_b) |-> !rx_full);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  assert_txrst_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_tx && $past(fcr_tx)) |-> (tx_cnt == '0));

  assert_rxrst_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_rx && $past(fcr_rx)) |-> (rx_cnt == '0));

  assert_isr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !any_ev) |=> (isr == 3'b000));

  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !(tx_stb || rx_ack_a || rx_ack_b));

endmodule

bind scfb_bridge scfb_bridge_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_stb    (tx_stb),
  .rx_ack_a  (rx_ack_a),
  .rx_ack_b  (rx_ack_b),
  .cfg_rxsrc (cfg_rxsrc),
  .cfg_en    (cfg_en),
  .tx_empty  (tx_empty),
  .rx_full   (rx_full),
  .fcr_tx    (fcr_tx),
  .fcr_rx    (fcr_rx),
  .tx_cnt    (tx_cnt),
  .rx_cnt    (rx_cnt),
  .isr_rd    (isr_rd),
  .any_ev    (any_ev),
  .isr       (isr)
);

// File: tb/scfb_bridge_bench.sv
`timescale 1ns/1ps
module scfb_bridge_bench;

  localparam int DEPTH    = 1024;
  localparam int TICK_DIV = 4;
  localparam int H        = DEPTH / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] host_addr = 4'h0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       ch_a_wreq = 1'b0, ch_a_dreq = 1'b0, ch_b_wreq = 1'b0;
  logic [7:0] rxd_a = 8'h00, rxd_b = 8'h00;
  logic       tx_stb, rx_ack_a, rx_ack_b, irq;
  logic [7:0] tx_data;
  logic       ctrl_irq = 1'b0, test_irq = 1'b0;

  always #2.5 clk = ~clk;

  scfb_bridge #(.DEPTH(DEPTH), .TICK_DIV(TICK_DIV)) u_scfb_bridge (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ch_a_wreq(ch_a_wreq), .ch_a_dreq(ch_a_dreq), .ch_b_wreq(ch_b_wreq),
    .rxd_a(rxd_a), .rxd_b(rxd_b), .tx_stb(tx_stb), .tx_data(tx_data),
    .rx_ack_a(rx_ack_a), .rx_ack_b(rx_ack_b), .ctrl_irq(ctrl_irq),
    .test_irq(test_irq), .irq(irq)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    done = 1'b0;
  byte unsigned pat = 8'h00;

  // Behavioural reference model state
  byte unsigned txq[$];
  byte unsigned rxq[$];
  bit       m_en, m_src, m_txr, m_rxr;
  bit [1:0] m_isel;
  bit [2:0] m_isr;
  bit [7:0] m_tmo, m_idle;
  int       m_pre;
  bit       m_fired;

  function automatic bit m_txreq();
    return m_src ? ch_a_wreq : ch_a_dreq;
  endfunction
  function automatic bit m_rxreq();
    return m_src ? ch_b_wreq : ch_a_wreq;
  endfunction
  function automatic bit m_stb();
    return m_en && m_txreq() && (txq.size() > 0) && !m_txr;
  endfunction
  function automatic bit m_acc();
    return m_en && m_rxreq() && (rxq.size() < DEPTH) && !m_rxr;
  endfunction

  function automatic logic [7:0] m_rdata(input logic [3:0] a);
    case (a)
      4'h7: return {2'b00, m_isel, 2'b00, m_src, m_en};
      4'h8: return {5'b0, m_isr};
      4'h9: return {1'b0, rxq.size() >= H, rxq.size() == DEPTH, rxq.size() == 0,
                    1'b0, txq.size() >= H, txq.size() == DEPTH, txq.size() == 0};
      4'hA: return {6'b0, m_rxr, m_txr};
      4'hD: return m_tmo;
      4'hE: return (rxq.size() == 0) ? 8'h00 : rxq[0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit m_irq();
    case (m_isel)
      2'd1: return ctrl_irq;
      2'd2: return |m_isr;
      2'd3: return test_irq;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_en = 0; m_src = 0; m_txr = 0; m_rxr = 0; m_isel = 0;
      m_isr = 0; m_tmo = 0; m_idle = 0; m_pre = 0; m_fired = 0;
    end else begin
      bit push_tx, pop_tx, push_rx, pop_rx, ev_d, ev_h, ev_t, tk;
      bit [7:0] nx, rb;
      push_tx = host_wr && host_addr == 4'hE && txq.size() < DEPTH && !m_txr;
      pop_tx  = m_stb();
      push_rx = m_acc();
      pop_rx  = host_rd && host_addr == 4'hE && rxq.size() > 0 && !m_rxr;
      rb      = m_src ? rxd_b : rxd_a;
      ev_d = pop_tx && !push_tx && txq.size() == 1;
      ev_h = push_rx && !pop_rx && rxq.size() == H - 1;
      ev_t = 0;
      tk   = (m_pre == TICK_DIV - 1);
      if (push_rx || rxq.size() == 0 || m_rxr) begin
        m_idle = 0; m_fired = 0;
      end else if (tk && !m_fired && m_tmo != 0) begin
        nx = m_idle + 8'd1;
        if (nx == m_tmo) begin ev_t = 1; m_fired = 1; end
        m_idle = nx;
      end
      m_pre = tk ? 0 : m_pre + 1;
      m_isr = ((host_rd && host_addr == 4'h8) ? 3'b000 : m_isr) | {ev_t, ev_h, ev_d};
      if (m_txr) txq.delete();
      else begin
        if (pop_tx) void'(txq.pop_front());
        if (push_tx) txq.push_back(host_wdata);
      end
      if (m_rxr) rxq.delete();
      else begin
        if (pop_rx) void'(rxq.pop_front());
        if (push_rx) rxq.push_back(rb);
      end
      if (host_wr && host_addr == 4'h7) begin
        m_en = host_wdata[0]; m_src = host_wdata[1]; m_isel = host_wdata[5:4];
      end
      if (host_wr && host_addr == 4'hA) begin
        m_txr = host_wdata[0]; m_rxr = host_wdata[1];
      end
      if (host_wr && host_addr == 4'hD) m_tmo = host_wdata;
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] act=%0h exp=%0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit e_stb, e_acc;
    if (!rst_n || done) return;
    e_stb = m_stb();
    e_acc = m_acc();
    cmp("tx_stb R3", tx_stb, e_stb);
    if (e_stb) cmp("tx_data R3", tx_data, txq[0]);
    cmp("rx_ack_a R4", rx_ack_a, e_acc && !m_src);
    cmp("rx_ack_b R4", rx_ack_b, e_acc && m_src);
    cmp("irq R10", irq, m_irq());
    cmp("host_rdata R6", host_rdata, m_rdata(host_addr));
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) begin
      rxd_a = pat; rxd_b = pat ^ 8'h5A; pat++;
      #1 check_all();
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    cyc();
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    host_addr = a; host_rd = 1'b1;
    cyc();
    host_rd = 1'b0;
  endtask

  // Literal check of a register value, independent of the model.
  task automatic expect_rd(input logic [3:0] a, input logic [7:0] v, input string tag);
    host_addr = a; host_rd = 1'b1;
    #1 cmp(tag, host_rdata, v);
    cyc();
    host_rd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog %s run did not complete", phase);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(2);

    phase = "R1";
    expect_rd(4'h9, 8'h11, "fsr after reset R1");
    expect_rd(4'h8, 8'h00, "isr after reset R1");
    expect_rd(4'h7, 8'h00, "cfg after reset R1");

    phase = "R11";
    wr(4'hE, 8'hA1); wr(4'hE, 8'hB2); wr(4'hE, 8'hC3);
    ch_a_dreq = 1; ch_a_wreq = 1; ch_b_wreq = 1;
    cyc(4);
    expect_rd(4'h9, 8'h10, "disabled holds tx R11");
    ch_a_wreq = 0; ch_b_wreq = 0;

    phase = "R3";
    wr(4'h7, 8'h01);
    cyc(5);
    expect_rd(4'h9, 8'h11, "tx drained R3");
    ch_a_dreq = 0;
    expect_rd(4'h8, 8'h01, "drain cause R8");
    phase = "R8";
    expect_rd(4'h8, 8'h00, "isr cleared by read R8");

    phase = "R4";
    ch_a_wreq = 1; cyc(3); ch_a_wreq = 0;
    ch_b_wreq = 1; cyc(2); ch_b_wreq = 0;
    phase = "R2";
    rd(4'hE); rd(4'hE); rd(4'hE);
    expect_rd(4'hE, 8'h00, "empty data read R2");

    phase = "R4";
    wr(4'hE, 8'h11); wr(4'hE, 8'h22); wr(4'hE, 8'h33);
    wr(4'h7, 8'h03);
    ch_a_dreq = 1; cyc(3); ch_a_dreq = 0;
    ch_a_wreq = 1; cyc(2); ch_a_wreq = 0;
    ch_b_wreq = 1; ch_a_dreq = 1; cyc(3); ch_b_wreq = 0; ch_a_dreq = 0;
    rd(4'hE); rd(4'hE);
    ch_a_wreq = 1; cyc(3); ch_a_wreq = 0;

    phase = "R7";
    ch_b_wreq = 1;
    wr(4'hA, 8'h03);
    wr(4'hE, 8'h77);
    cyc(3);
    expect_rd(4'h9, 8'h11, "reset holds empty R7");
    wr(4'hA, 8'h00);
    ch_b_wreq = 0;
    expect_rd(4'h9, 8'h11, "empty after reset R7");
    rd(4'h8);

    phase = "R10";
    wr(4'h7, 8'h10); ctrl_irq = 1; cyc(2); ctrl_irq = 0; test_irq = 1; cyc(2);
    wr(4'h7, 8'h30); cyc(2); test_irq = 0; cyc(2);
    wr(4'h7, 8'h00); ctrl_irq = 1; test_irq = 1; cyc(2); ctrl_irq = 0; test_irq = 0;

    phase = "R9";
    wr(4'hD, 8'h03);
    wr(4'h7, 8'h21);
    ch_a_wreq = 1; cyc(); ch_a_wreq = 0;
    cyc(8);
    cmp("irq low before timeout R9", irq, 1'b0);
    cyc(12);
    cmp("irq after timeout R9", irq, 1'b1);
    expect_rd(4'h8, 8'h04, "timeout cause R9");
    cyc(30);
    expect_rd(4'h8, 8'h00, "timeout fires once R9");
    wr(4'hD, 8'h00);
    ch_a_wreq = 1; cyc(); ch_a_wreq = 0;
    cyc(40);
    expect_rd(4'h8, 8'h00, "zero limit disables R9");
    wr(4'hA, 8'h02); wr(4'hA, 8'h00);

    phase = "R5";
    wr(4'h7, 8'h00);
    for (int i = 0; i < DEPTH; i++) wr(4'hE, 8'(i * 7));
    wr(4'hE, 8'hEE);
    expect_rd(4'h9, 8'h16, "tx full flags R5");
    phase = "R6";
    wr(4'h9, 8'h00);
    expect_rd(4'h9, 8'h16, "fsr write ignored R6");
    wr(4'h7, 8'h01);
    ch_a_dreq = 1; cyc(DEPTH + 4); ch_a_dreq = 0;
    expect_rd(4'h9, 8'h11, "tx drained fully R6");
    rd(4'h8);
    phase = "R5";
    ch_a_wreq = 1; cyc(DEPTH + 6); ch_a_wreq = 0;
    expect_rd(4'h9, 8'h61, "rx full flags R5");
    expect_rd(4'h8, 8'h02, "rx half cause R8");
    for (int i = 0; i < 4; i++) rd(4'hE);
    ch_a_wreq = 1; cyc(6); ch_a_wreq = 0;
    wr(4'hA, 8'h02); wr(4'hA, 8'h00);
    expect_rd(4'h9, 8'h11, "rx emptied R7");

    cyc(4);
    finish_run();
  end

endmodule